// File: doc/BRIEF.md
# Line Interface Alarm and Control Register Bank

This block is the register bank and interrupt combiner for a seven-channel line interface. Three kinds of alarm come from detectors outside the block: signal loss per channel, transmit-clock loss per channel, and one master-clock loss. Each alarm passes through a two-flop synchronizer and can be read back live. Status is never latched, so a read always shows the current condition of the line.

Two layers of masking sit in front of the single active-high interrupt. The first layer is a mask bit for each alarm. The second layer is a per-channel interrupt mask in that channel's control register. Master-clock loss forces every signal-loss status bit high. Its interrupt can therefore only be silenced fully if the per-channel signal-loss masks are set as well as its own mask.

Each channel also has a control register. It exports a 3-bit line-length code, remote and local loopback enables, a polarity select and a power-down bit to the rest of the channel. A single receive-gating bit is exported as well. The bus side is a plain address, write strobe and write data, with read data decoded combinationally from the address.

Top module: `line_alarm_regs`

## Requirements
- R1: After reset the following values hold. Address 2 reads 0xFE. Address 3 reads 0xFF. Addresses 6..12 each read 0x07, which means power-down=1, channel mask=1, polarity=1 and all other fields 0. The interrupt output is 0 and the receive-gating output is 0.
- R2: Address 0 reads the signal-loss status of channel n (1..7) in bit n, with bit 0 always 0. The status follows its input after two clock edges and is not sticky: it returns to 0 when the input clears.
- R3: Address 1 reads the transmit-clock-loss status of channel n in bit n and master-clock loss in bit 0. It uses the same two-edge synchronizer and is also live rather than latched.
- R4: While master-clock loss status is 1, every signal-loss status bit (address 0, bits 7..1) reads 1.
- R5: Address 2 holds the signal-loss mask of channel n in bit n, and the receive-gating bit in bit 0, which drives the receive-gating output. Address 3 holds the transmit-clock-loss mask of channel n in bit n, and the master-clock-loss mask in bit 0. Both registers are readable and writable.
- R6: Address 5+n is the control register of channel n. Its fields are: bits 7..5 line-length code, bit 4 remote loopback, bit 3 local loopback, bit 2 polarity, bit 1 channel interrupt mask, bit 0 power-down. Each field drives the output of the same name for that channel, and the register reads back as written.
- R7: The interrupt output is registered. One clock edge after the synchronized status and the masks are set, it goes 1 if any channel has a signal-loss or transmit-clock-loss status of 1 while both that alarm's mask bit and the channel's interrupt mask bit are 0. Otherwise it stays 0 (apart from R10).
- R8: A set mask bit blocks only the interrupt. The matching status bit still reads back as 1.
- R9: Writes to addresses 0, 1, 4, 5 and 13..15 change no register and no output. Reads of addresses 4, 5 and 13..15 return 0x00.
- R10: Master-clock loss raises the interrupt whenever its own mask (address 3, bit 0) is 0, independent of the channel interrupt masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| sigLossIn | input | 7 | Raw signal-loss alarms, bit k = channel k+1 |
| txClkLossIn | input | 7 | Raw transmit-clock-loss alarms, bit k = channel k+1 |
| mclkLossIn | input | 1 | Raw master-clock-loss alarm |
| irqOut | output | 1 | Combined interrupt, active high, registered |
| rxGateEn | output | 1 | Receive-gating control |
| lineLenCode | output | 21 | Line-length codes, bits 3k+2..3k = channel k+1 |
| remLoopEn | output | 7 | Remote loopback enables |
| locLoopEn | output | 7 | Local loopback enables |
| polaritySel | output | 7 | Polarity selects |
| powerDown | output | 7 | Power-down controls |

## Verification
The two kinds of state show up differently at the ports. A wrong mask or channel register shows up at once: it is visible in the combinational read data in the same cycle, and it appears on irqOut one edge after an alarm is present. A wrong synchronizer stage or a status bit that stays latched appears as read data that disagrees with the delayed raw inputs two edges after the inputs move. A missing master-clock cascade shows as address 0 reading less than all ones while the master-clock bit reads one. Every read value and every exported field is compared against a reference model on every clock, so any such divergence is reported in the cycle it first becomes visible.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int CH_NUM    = 7;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 4;
  localparam int CTRL_BASE = 6;
  localparam int SYNC_LEN  = 2;
  localparam int LEN_W     = 3;
  localparam int IDX_W     = $clog2(CH_NUM);
  localparam int RAW_W     = 2 * CH_NUM + 1;

  // field positions inside a channel control register
  localparam int F_PD    = 0;
  localparam int F_CHMSK = 1;
  localparam int F_POL   = 2;
  localparam int F_LLOOP = 3;
  localparam int F_RLOOP = 4;
  localparam int F_LEN   = 5;

  localparam logic [REG_W-1:0] CHAN_RST = 8'h07;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOS, RD_LOTC, RD_MASK_SIG, RD_MASK_TX, RD_CHAN
  } rdSel_e;

  typedef struct packed {
    logic              wrMaskSig;
    logic              wrMaskTx;
    logic [CH_NUM-1:0] wrChan;
    rdSel_e            rdSel;
    logic [IDX_W-1:0]  chIdx;
  } strobe_t;
endpackage

// File: rtl/lar_ctrl.sv
module lar_ctrl
  import lar_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int BASE = CTRL_BASE
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  output strobe_t       strb
);
  localparam int LAST = BASE + CH_NUM - 1;

  logic [AW-1:0] chOff;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    chOff      = busAddr - AW'(BASE);
    if (int'(busAddr) >= BASE && int'(busAddr) <= LAST) begin
      strb.rdSel                      = RD_CHAN;
      strb.chIdx                      = chOff[IDX_W-1:0];
      strb.wrChan[chOff[IDX_W-1:0]]   = busWrEn;
    end else begin
      case (int'(busAddr))
        0: strb.rdSel = RD_LOS;
        1: strb.rdSel = RD_LOTC;
        2: begin
          strb.rdSel     = RD_MASK_SIG;
          strb.wrMaskSig = busWrEn;
        end
        3: begin
          strb.rdSel    = RD_MASK_TX;
          strb.wrMaskTx = busWrEn;
        end
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lar_data.sv
module lar_data
  import lar_pkg::*;
#(
  parameter int NSYNC = SYNC_LEN
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [REG_W-1:0]        wrData,
  output logic [REG_W-1:0]        rdData,
  input  logic [CH_NUM-1:0]       sigLossIn,
  input  logic [CH_NUM-1:0]       txClkLossIn,
  input  logic                    mclkLossIn,
  output logic                    irqOut,
  output logic                    rxGateEn,
  output logic [CH_NUM*LEN_W-1:0] lineLenCode,
  output logic [CH_NUM-1:0]       remLoopEn,
  output logic [CH_NUM-1:0]       locLoopEn,
  output logic [CH_NUM-1:0]       polaritySel,
  output logic [CH_NUM-1:0]       powerDown
);
  logic [RAW_W-1:0] rawIn;
  logic [RAW_W-1:0] syncPipe [NSYNC];

  assign rawIn = {mclkLossIn, txClkLossIn, sigLossIn};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[g] <= '0;
        else       syncPipe[g] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[g] <= '0;
        else       syncPipe[g] <= syncPipe[g-1];
      end
    end
  end

  logic [CH_NUM-1:0] sigStat, txStat, losStat;
  logic              mclkStat;

  assign sigStat  = syncPipe[NSYNC-1][CH_NUM-1:0];
  assign txStat   = syncPipe[NSYNC-1][2*CH_NUM-1:CH_NUM];
  assign mclkStat = syncPipe[NSYNC-1][RAW_W-1];
  // master-clock loss drags every signal-loss bit high
  assign losStat  = sigStat | {CH_NUM{mclkStat}};

  logic [CH_NUM-1:0] sigMask, txMask;
  logic              mclkMask, rxGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigMask  <= '1;
      rxGate   <= 1'b0;
      txMask   <= '1;
      mclkMask <= 1'b1;
    end else begin
      if (strb.wrMaskSig) {sigMask, rxGate}  <= wrData;
      if (strb.wrMaskTx)  {txMask, mclkMask} <= wrData;
    end
  end

  logic [REG_W-1:0]  chanReg [CH_NUM];
  logic [CH_NUM-1:0] chMask;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              chanReg[c] <= CHAN_RST;
      else if (strb.wrChan[c]) chanReg[c] <= wrData;
    end
    assign lineLenCode[c*LEN_W +: LEN_W] = chanReg[c][F_LEN +: LEN_W];
    assign remLoopEn[c]   = chanReg[c][F_RLOOP];
    assign locLoopEn[c]   = chanReg[c][F_LLOOP];
    assign polaritySel[c] = chanReg[c][F_POL];
    assign chMask[c]      = chanReg[c][F_CHMSK];
    assign powerDown[c]   = chanReg[c][F_PD];
  end

  assign rxGateEn = rxGate;

  logic [CH_NUM-1:0] chAlarm;
  logic              irqNext;

  assign chAlarm = ((losStat & ~sigMask) | (txStat & ~txMask)) & ~chMask;
  assign irqNext = (|chAlarm) | (mclkStat & ~mclkMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqNext;
  end

  always_comb begin
    case (strb.rdSel)
      RD_LOS:      rdData = {losStat, 1'b0};
      RD_LOTC:     rdData = {txStat, mclkStat};
      RD_MASK_SIG: rdData = {sigMask, rxGate};
      RD_MASK_TX:  rdData = {txMask, mclkMask};
      RD_CHAN:     rdData = (int'(strb.chIdx) < CH_NUM) ? chanReg[strb.chIdx] : '0;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/line_alarm_regs.sv
module line_alarm_regs
  import lar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic [6:0]  sigLossIn,
  input  logic [6:0]  txClkLossIn,
  input  logic        mclkLossIn,
  output logic        irqOut,
  output logic        rxGateEn,
  output logic [20:0] lineLenCode,
  output logic [6:0]  remLoopEn,
  output logic [6:0]  locLoopEn,
  output logic [6:0]  polaritySel,
  output logic [6:0]  powerDown
);
  strobe_t strb;

  lar_ctrl #(.AW(ADDR_W), .BASE(CTRL_BASE)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  lar_data #(.NSYNC(SYNC_LEN)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .sigLossIn   (sigLossIn),
    .txClkLossIn (txClkLossIn),
    .mclkLossIn  (mclkLossIn),
    .irqOut      (irqOut),
    .rxGateEn    (rxGateEn),
    .lineLenCode (lineLenCode),
    .remLoopEn   (remLoopEn),
    .locLoopEn   (locLoopEn),
    .polaritySel (polaritySel),
    .powerDown   (powerDown)
  );
endmodule

// File: rtl/line_alarm_regs_chk.sv
module line_alarm_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic        busWrEn,
  input logic [7:0]  busRdData,
  input logic        irqOut,
  input logic        rxGateEn,
  input logic [20:0] lineLenCode,
  input logic [6:0]  remLoopEn,
  input logic [6:0]  locLoopEn,
  input logic [6:0]  polaritySel,
  input logic [6:0]  powerDown,
  input logic        mclkSt
);
  // R1
  reset_values_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (powerDown == 7'h7f && polaritySel == 7'h7f && !irqOut && !rxGateEn
                     && lineLenCode == '0 && remLoopEn == '0 && locLoopEn == '0));

  // R2
  los_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == 4'd0 |-> !busRdData[0]);

  // R4
  mclk_cascade_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mclkSt && busAddr == 4'd0) |-> busRdData[7:1] == 7'h7f);

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(powerDown) && $stable(polaritySel) && $stable(lineLenCode)
                  && $stable(remLoopEn) && $stable(locLoopEn) && $stable(rxGateEn)));

  // R9
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr <= 4'd1 || busAddr == 4'd4 || busAddr == 4'd5 || busAddr >= 4'd13))
    |=> ($stable(powerDown) && $stable(polaritySel) && $stable(lineLenCode)
         && $stable(remLoopEn) && $stable(locLoopEn) && $stable(rxGateEn)));

  // R9
  reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'd4 || busAddr == 4'd5 || busAddr >= 4'd13) |-> busRdData == 8'h00);
endmodule

bind line_alarm_regs line_alarm_regs_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busRdData   (busRdData),
  .irqOut      (irqOut),
  .rxGateEn    (rxGateEn),
  .lineLenCode (lineLenCode),
  .remLoopEn   (remLoopEn),
  .locLoopEn   (locLoopEn),
  .polaritySel (polaritySel),
  .powerDown   (powerDown),
  .mclkSt      (u_data.mclkStat)
);

// File: tb/test_line_alarm_regs.sv
module test_line_alarm_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [6:0]  sigLossIn = '0;
  logic [6:0]  txClkLossIn = '0;
  logic        mclkLossIn = 1'b0;
  logic        irqOut, rxGateEn;
  logic [20:0] lineLenCode;
  logic [6:0]  remLoopEn, locLoopEn, polaritySel, powerDown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_alarm_regs i_line_alarm_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sigLossIn(sigLossIn),
    .txClkLossIn(txClkLossIn), .mclkLossIn(mclkLossIn), .irqOut(irqOut),
    .rxGateEn(rxGateEn), .lineLenCode(lineLenCode), .remLoopEn(remLoopEn),
    .locLoopEn(locLoopEn), .polaritySel(polaritySel), .powerDown(powerDown)
  );

  // reference model state
  logic [14:0] hist[$];
  logic [6:0]  mSigMask, mTxMask;
  logic        mMclkMask, mRxGate, mIrq;
  logic [7:0]  mCtrl [7];

  function automatic logic [14:0] stNow();
    return (hist.size() > 1) ? hist[1] : 15'd0;
  endfunction

  function automatic logic [6:0] losNow();
    logic [14:0] s = stNow();
    return s[6:0] | {7{s[14]}};
  endfunction

  function automatic logic irqCalc();
    logic [14:0] s = stNow();
    logic [6:0] los = losNow();
    logic r = s[14] && !mMclkMask;
    for (int i = 0; i < 7; i++)
      if (!mCtrl[i][1] && ((los[i] && !mSigMask[i]) || (s[7+i] && !mTxMask[i]))) r = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] readModel(input int a);
    logic [14:0] s = stNow();
    case (a)
      0: return {losNow(), 1'b0};
      1: return {s[13:7], s[14]};
      2: return {mSigMask, mRxGate};
      3: return {mTxMask, mMclkMask};
      default: return (a >= 6 && a <= 12) ? mCtrl[a-6] : 8'h00;
    endcase
  endfunction

  function automatic string readTag(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2, 3: return "R5";
      default: return (a >= 6 && a <= 12) ? "R6" : "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {};
      hist.push_front(15'd0);
      hist.push_front(15'd0);
      mSigMask = 7'h7f; mTxMask = 7'h7f; mMclkMask = 1'b1; mRxGate = 1'b0; mIrq = 1'b0;
      for (int i = 0; i < 7; i++) mCtrl[i] = 8'h07;
    end else begin
      mIrq = irqCalc();
      if (busWrEn) begin
        case (int'(busAddr))
          2: {mSigMask, mRxGate} = busWrData;
          3: {mTxMask, mMclkMask} = busWrData;
          default: if (busAddr >= 4'd6 && busAddr <= 4'd12) mCtrl[int'(busAddr) - 6] = busWrData;
        endcase
      end
      hist.push_front({mclkLossIn, txClkLossIn, sigLossIn});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [20:0] eLen;
      logic [6:0] eR, eL, eP, eD;
      for (int i = 0; i < 7; i++) begin
        eLen[i*3 +: 3] = mCtrl[i][7:5];
        eR[i] = mCtrl[i][4]; eL[i] = mCtrl[i][3]; eP[i] = mCtrl[i][2]; eD[i] = mCtrl[i][0];
      end
      chk(readTag(int'(busAddr)), busRdData, readModel(int'(busAddr)));
      chk("R7 irq", irqOut, mIrq);
      chk("R5 rxgate", rxGateEn, mRxGate);
      chk("R6 fields", {lineLenCode, eR ^ remLoopEn, eL ^ locLoopEn, eP ^ polaritySel, eD ^ powerDown},
          {eLen, 28'd0});
    end
  end

  task automatic stepTo(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    busAddr = 4'(a); busWrData = 8'(d); busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    busAddr = 4'(a); busWrEn = 1'b0;
    @(negedge clk);
    chk(tag, busRdData, exp);
  endtask

  task automatic irqChk(input int exp, input string tag);
    @(negedge clk);
    chk(tag, irqOut, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    stepTo(3);
    rstN = 1'b1;
    // R1 reset state
    rdChk(2, 8'hFE, "R1 sig mask reset");
    rdChk(3, 8'hFF, "R1 tx mask reset");
    rdChk(6, 8'h07, "R1 ch1 ctrl reset");
    rdChk(12, 8'h07, "R1 ch7 ctrl reset");
    chk("R1 irq reset", irqOut, 0);
    chk("R1 powerdown reset", powerDown, 7'h7f);

    // signal loss on channel 3 with both masks opened
    wr(2, 8'hF6);
    wr(8, 8'h05);
    sigLossIn = 7'h04;
    stepTo(4);
    rdChk(0, 8'h08, "R2 ch3 signal loss");
    irqChk(1, "R7 ch3 unmasked irq");
    wr(2, 8'hFE);
    stepTo(2);
    irqChk(0, "R7 mask set drops irq");
    rdChk(0, 8'h08, "R8 masked status still readable");
    sigLossIn = 7'h00;
    stepTo(3);
    rdChk(0, 8'h00, "R2 status not sticky");

    // transmit-clock loss on channel 5, blocked by channel mask first
    wr(3, 8'hDF);
    txClkLossIn = 7'h10;
    stepTo(4);
    irqChk(0, "R7 channel mask blocks");
    rdChk(1, 8'h20, "R3 ch5 tx clock loss");
    wr(10, 8'h05);
    stepTo(2);
    irqChk(1, "R7 channel mask cleared");
    txClkLossIn = 7'h00;
    stepTo(4);
    irqChk(0, "R7 alarm gone");

    // master-clock loss cascade
    mclkLossIn = 1'b1;
    stepTo(4);
    rdChk(0, 8'hFE, "R4 cascade into signal loss");
    rdChk(1, 8'h01, "R3 master clock bit");
    irqChk(0, "R10 all masks set");
    wr(3, 8'hDE);
    stepTo(2);
    irqChk(1, "R10 mclk mask cleared");
    mclkLossIn = 1'b0;
    stepTo(4);
    irqChk(0, "R10 mclk gone");

    // ignored writes and reserved reads
    wr(0, 8'hAA); wr(1, 8'h55); wr(4, 8'hFF); wr(13, 8'hFF); wr(15, 8'h3C);
    rdChk(4, 8'h00, "R9 reserved 4");
    rdChk(13, 8'h00, "R9 reserved 13");
    rdChk(15, 8'h00, "R9 reserved 15");
    rdChk(0, 8'h00, "R9 status write ignored");
    rdChk(3, 8'hDE, "R9 masks unchanged");

    // R5 receive gating
    wr(2, 8'h01);
    rdChk(2, 8'h01, "R5 mask readback");
    chk("R5 rxgate out", rxGateEn, 1);

    // R6 control fields
    wr(12, 8'hB5);
    rdChk(12, 8'hB5, "R6 ch7 readback");
    chk("R6 ch7 length", lineLenCode[20:18], 3'b101);
    chk("R6 ch7 bits", {remLoopEn[6], locLoopEn[6], polaritySel[6], powerDown[6]}, 4'b1011);
    wr(6, 8'h48);
    chk("R6 ch1 length", lineLenCode[2:0], 3'b010);
    chk("R6 ch1 bits", {remLoopEn[0], locLoopEn[0], polaritySel[0], powerDown[0]}, 4'b0100);

    // pseudo-random sweep, model compared every clock
    begin
      logic [31:0] lf = 32'h1234_5678;
      for (int k = 0; k < 600; k++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        @(posedge clk); #1;
        busAddr = lf[3:0];
        busWrData = lf[11:4];
        busWrEn = (lf[14:12] == 3'd0);
        if (lf[17:15] == 3'd0) sigLossIn = lf[24:18];
        if (lf[20:18] == 3'd1) txClkLossIn = lf[31:25];
        if (lf[23:21] == 3'd2) mclkLossIn = lf[26];
      end
      busWrEn = 1'b0;
    end
    stepTo(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule